// File: doc/BRIEF.md
# Modulo Alarm Timer

An up-counting timer peripheral that raises a one-shot alarm. Software programs a start value and a modulus, then picks a count source and a power-of-two prescale. On each prescaled tick the counter climbs by one. On the tick after it has reached the modulus, it reloads the start value and records an overflow. An alarm of N ticks is therefore set up with start 0 and modulus N-1.

An overflow-threshold field holds the flag back until a programmed number of overflows has happened. The flag drives the interrupt line when the interrupt enable is set. Clearing is a two-step handshake: read the flag as 1, then write 0. If a clear and a flag-setting overflow land in the same cycle, the overflow wins.

All registers sit on a simple synchronous bus. Write data is taken at the clock edge, and read data is a combinational function of the address and the current state. The fixed-frequency source arrives as a one-cycle strobe in the bus clock domain.

Top module: `mod_alarm_timer`

## Requirements
- R1: After reset the control word, counter and start value read 0, the modulus reads 0x0000FFFF and the interrupt is low.
- R2: On each prescaled tick the counter increments by one. If the counter equals the modulus before the tick, it loads the start value instead and an overflow occurs. With no tick and no counter write, the counter holds.
- R3: A bus write of any data to address 1 (counter) loads the counter with the start value. It also restarts the overflow count, and that cycle produces no overflow.
- R4: The prescale field PS (control bits 4:2) gives one tick per 2^PS source events. The prescale count is cleared whenever the source is off.
- R5: The source field (control bits 1:0) selects the source: 0 and 3 stop counting, 1 uses every bus clock cycle, and 2 uses the strobe on `fixed_tick`.
- R6: The overflow flag (control bit 7) is set on an overflow only once THR+1 overflows have happened since the last flag set or counter write. THR is control bits 11:8.
- R7: `irq` is high exactly while both the flag and the interrupt enable (control bit 5) are 1.
- R8: Writing 0 to control bit 7 clears the flag only if the control word was read with the flag at 1 since the flag was last set. Writing 1 to bit 7 has no effect on the flag.
- R9: A clear that coincides with a flag-setting overflow leaves the flag at 1 and drops the earlier read, so a fresh read is needed before the next clear.
- R10: Reserved bits read 0 and are not stored: control bits 31:12 and 6, and bits 31:16 of the counter, modulus (address 2) and start value (address 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (arms the flag clear) |
| bus_addr | input | 2 | Register select: 0 control, 1 counter, 2 modulus, 3 start |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the selected register |
| fixed_tick | input | 1 | Fixed-frequency one-cycle strobe |
| irq | output | 1 | Overflow interrupt |

## Verification
The assertions assume that a read and a write never target the control word in the same cycle. They also assume that `fixed_tick` is a single-cycle strobe aligned to the clock. The stimulus issues at most one bus access per cycle and generates the strobe every third cycle from a bench counter. To hit the set-versus-clear race, the bench waits until its own model shows the counter sitting on the modulus with the overflow threshold met. It then places the clear write in exactly that cycle.

// File: rtl/mat_pkg.sv
package mat_pkg;
  localparam int SRC_W = 2;

  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_COUNT = 2'd1,
    REG_MOD   = 2'd2,
    REG_START = 2'd3
  } reg_sel_e;

  typedef enum logic [SRC_W-1:0] {
    SRC_OFF   = 2'd0,
    SRC_BUS   = 2'd1,
    SRC_FIXED = 2'd2,
    SRC_OFF_B = 2'd3
  } clk_src_e;
endpackage

// File: rtl/mat_prescaler.sv
module mat_prescaler #(
  parameter int PS_W = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [mat_pkg::SRC_W-1:0] src_sel,
  input  logic                     fixed_tick,
  input  logic [PS_W-1:0]          ps,
  output logic                     tick
);
  import mat_pkg::*;

  localparam int DIV_W = (1 << PS_W) - 1;

  // Terminal count for a divide by 2^p: p low-order ones.
  function automatic logic [DIV_W-1:0] div_mask(input logic [PS_W-1:0] p);
    logic [DIV_W-1:0] m;
    for (int i = 0; i < DIV_W; i++) m[i] = (i < int'(p));
    return m;
  endfunction

  logic [DIV_W-1:0] div_q;
  logic             running;
  logic             src_evt;
  logic             at_term;

  always_comb begin
    unique case (src_sel)
      SRC_BUS:   begin running = 1'b1; src_evt = 1'b1;       end
      SRC_FIXED: begin running = 1'b1; src_evt = fixed_tick; end
      default:   begin running = 1'b0; src_evt = 1'b0;       end
    endcase
  end

  assign at_term = (div_q >= div_mask(ps));
  assign tick    = src_evt && at_term;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          div_q <= '0;
    else if (!running)   div_q <= '0;
    else if (src_evt)    div_q <= at_term ? '0 : div_q + 1'b1;
  end
endmodule

// File: rtl/mat_counter.sv
module mat_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] start_val,
  input  logic [CNT_W-1:0] mod_val,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  // Value after one tick: reload at the modulus, else step up.
  function automatic logic [CNT_W-1:0] step_count(
    input logic [CNT_W-1:0] cur,
    input logic [CNT_W-1:0] top,
    input logic [CNT_W-1:0] base
  );
    return (cur == top) ? base : cur + 1'b1;
  endfunction

  assign wrap = tick && !load && (cnt == mod_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (load)  cnt <= start_val;
    else if (tick)  cnt <= step_count(cnt, mod_val, start_val);
  end
endmodule

// File: rtl/mat_ovf_flag.sv
module mat_ovf_flag #(
  parameter int THR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrap,
  input  logic [THR_W-1:0] thr,
  input  logic             restart,
  input  logic             clr_req,
  input  logic             rd_probe,
  output logic             flag,
  output logic             set_evt
);
  logic [THR_W-1:0] ovc_q;
  logic             armed_q;
  logic             clr_ok;

  assign set_evt = wrap && (ovc_q >= thr);
  assign clr_ok  = clr_req && armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ovc_q <= '0;
    else if (restart) ovc_q <= '0;
    else if (wrap)    ovc_q <= (ovc_q >= thr) ? '0 : ovc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag    <= 1'b0;
      armed_q <= 1'b0;
    end else if (set_evt) begin
      flag    <= 1'b1;
      armed_q <= 1'b0;
    end else if (clr_ok) begin
      flag    <= 1'b0;
      armed_q <= 1'b0;
    end else if (rd_probe && flag) begin
      armed_q <= 1'b1;
    end
  end
endmodule

// File: rtl/mod_alarm_timer.sv
module mod_alarm_timer #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int PS_W   = 3,
  parameter int THR_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              fixed_tick,
  output logic              irq
);
  import mat_pkg::*;

  localparam int PS_LSB   = SRC_W;
  localparam int IE_BIT   = PS_LSB + PS_W;
  localparam int FLAG_BIT = IE_BIT + 2;
  localparam int THR_LSB  = FLAG_BIT + 1;
  localparam int CTRL_W   = THR_LSB + THR_W;

  logic [SRC_W-1:0] csel_q;
  logic [PS_W-1:0]  ps_q;
  logic             ie_q;
  logic [THR_W-1:0] thr_q;
  logic [CNT_W-1:0] mod_q;
  logic [CNT_W-1:0] init_q;
  logic [CNT_W-1:0] cnt_q;

  logic wr_ctrl, wr_mod, wr_start;
  logic cnt_wr, clr_req, rd_probe;
  logic tick, wrap, set_evt, flag_q;

  logic unused_wdata;
  assign unused_wdata = ^bus_wdata[DATA_W-1:CTRL_W] ^ bus_wdata[IE_BIT+1];

  assign wr_ctrl  = bus_wr && (bus_addr == REG_CTRL);
  assign cnt_wr   = bus_wr && (bus_addr == REG_COUNT);
  assign wr_mod   = bus_wr && (bus_addr == REG_MOD);
  assign wr_start = bus_wr && (bus_addr == REG_START);
  assign clr_req  = wr_ctrl && !bus_wdata[FLAG_BIT];
  assign rd_probe = bus_rd && (bus_addr == REG_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csel_q <= '0;
      ps_q   <= '0;
      ie_q   <= 1'b0;
      thr_q  <= '0;
    end else if (wr_ctrl) begin
      csel_q <= bus_wdata[SRC_W-1:0];
      ps_q   <= bus_wdata[PS_LSB +: PS_W];
      ie_q   <= bus_wdata[IE_BIT];
      thr_q  <= bus_wdata[THR_LSB +: THR_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mod_q  <= '1;
      init_q <= '0;
    end else begin
      if (wr_mod)   mod_q  <= bus_wdata[CNT_W-1:0];
      if (wr_start) init_q <= bus_wdata[CNT_W-1:0];
    end
  end

  mat_prescaler #(.PS_W(PS_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .src_sel(csel_q), .fixed_tick(fixed_tick),
    .ps(ps_q), .tick(tick)
  );

  mat_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(cnt_wr),
    .start_val(init_q), .mod_val(mod_q), .cnt(cnt_q), .wrap(wrap)
  );

  mat_ovf_flag #(.THR_W(THR_W)) u_flag (
    .clk(clk), .rst_n(rst_n), .wrap(wrap), .thr(thr_q), .restart(cnt_wr),
    .clr_req(clr_req), .rd_probe(rd_probe), .flag(flag_q), .set_evt(set_evt)
  );

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      REG_CTRL: begin
        bus_rdata[SRC_W-1:0]          = csel_q;
        bus_rdata[PS_LSB +: PS_W]     = ps_q;
        bus_rdata[IE_BIT]             = ie_q;
        bus_rdata[FLAG_BIT]           = flag_q;
        bus_rdata[THR_LSB +: THR_W]   = thr_q;
      end
      REG_COUNT: bus_rdata[CNT_W-1:0] = cnt_q;
      REG_MOD:   bus_rdata[CNT_W-1:0] = mod_q;
      default:   bus_rdata[CNT_W-1:0] = init_q;
    endcase
  end

  assign irq = flag_q && ie_q;
endmodule

// File: rtl/mat_checker.sv
module mat_checker #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [1:0]        csel_q,
  input logic              tick,
  input logic              cnt_wr,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [CNT_W-1:0]  mod_q,
  input logic [CNT_W-1:0]  init_q,
  input logic              wrap,
  input logic              set_evt,
  input logic              clr_req,
  input logic              flag_q
);
  // R5
  stop_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csel_q == 2'd0 || csel_q == 2'd3) |-> !tick);

  // R2
  step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_wr && cnt_q != mod_q) |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));

  // R2
  wrap_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> cnt_q == $past(init_q));

  // R2
  hold_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cnt_wr) |=> $stable(cnt_q));

  // R3
  load_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> cnt_q == $past(init_q));

  // R6
  flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(set_evt));

  // R8
  flag_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(clr_req));

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_evt && clr_req) |=> flag_q);

  // R10
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr != 2'd0) |-> bus_rdata[DATA_W-1:CNT_W] == '0);
endmodule

bind mod_alarm_timer mat_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .csel_q(csel_q), .tick(tick), .cnt_wr(cnt_wr), .cnt_q(cnt_q),
  .mod_q(mod_q), .init_q(init_q), .wrap(wrap), .set_evt(set_evt),
  .clr_req(clr_req), .flag_q(flag_q)
);

// File: tb/mod_alarm_timer_bench.sv
module mod_alarm_timer_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        fixed_tick = 1'b0;
  logic        irq;

  int n_chk = 0, n_bad = 0, strobe_ph = 0;
  string cur_req = "R1";

  // behavioural reference state
  int m_cnt, m_mod, m_init, m_csel, m_ps, m_ie, m_flag, m_thr, m_ovc, m_arm, m_pcnt;

  always #(CLK_P/2) clk = ~clk;

  mod_alarm_timer u_mod_alarm_timer (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .fixed_tick(fixed_tick), .irq(irq)
  );

  function automatic logic [31:0] ctl(int src, int ps, int ie, int fl, int thr);
    return 32'((thr << 8) | (fl << 7) | (ie << 5) | (ps << 2) | src);
  endfunction

  function automatic logic [31:0] m_read(int a);
    case (a)
      0: return ctl(m_csel, m_ps, m_ie, m_flag, m_thr);
      1: return 32'(m_cnt);
      2: return 32'(m_mod);
      default: return 32'(m_init);
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_cnt = 0; m_mod = 'hFFFF; m_init = 0; m_csel = 0; m_ps = 0; m_ie = 0;
    m_flag = 0; m_thr = 0; m_ovc = 0; m_arm = 0; m_pcnt = 0;
  endtask

  task automatic model_step(logic wr, logic rd, int a, logic [31:0] d, logic ft);
    int lim; bit src, run, tk, cw, wrp, setv, clr;
    lim  = (1 << m_ps) - 1;
    run  = (m_csel == 1) || (m_csel == 2);
    src  = (m_csel == 1) || (m_csel == 2 && ft);
    tk   = src && (m_pcnt >= lim);
    cw   = wr && a == 1;
    wrp  = tk && !cw && (m_cnt == m_mod);
    setv = wrp && (m_ovc >= m_thr);
    clr  = wr && a == 0 && !d[7];
    if (!run) m_pcnt = 0; else if (src) m_pcnt = tk ? 0 : m_pcnt + 1;
    if (setv) begin m_flag = 1; m_arm = 0; end
    else if (clr && m_arm != 0) begin m_flag = 0; m_arm = 0; end
    else if (rd && a == 0 && m_flag != 0) m_arm = 1;
    if (cw) m_ovc = 0; else if (wrp) m_ovc = (m_ovc >= m_thr) ? 0 : (m_ovc + 1) % 16;
    if (cw) m_cnt = m_init;
    else if (tk) m_cnt = (m_cnt == m_mod) ? m_init : (m_cnt + 1) % 65536;
    if (wr && a == 0) begin
      m_csel = int'(d[1:0]); m_ps = int'(d[4:2]); m_ie = int'(d[5]); m_thr = int'(d[11:8]);
    end
    if (wr && a == 2) m_mod = int'(d[15:0]);
    if (wr && a == 3) m_init = int'(d[15:0]);
  endtask

  // one bus cycle, entered and left just after a falling edge
  task automatic cyc(logic wr, logic rd, int a, logic [31:0] d);
    bus_wr = wr; bus_rd = rd; bus_addr = 2'(a); bus_wdata = d;
    fixed_tick = (strobe_ph == 2);
    strobe_ph = (strobe_ph + 1) % 3;
    @(posedge clk);
    model_step(wr, rd, a, d, fixed_tick);
    @(negedge clk);
    check(cur_req, bus_rdata, m_read(a));
    check("R7", 32'(irq), 32'(m_flag & m_ie));
    bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic idle(int n, int a);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, a, '0);
  endtask

  task automatic peek(string req, int a, logic [31:0] exp);
    bus_addr = 2'(a);
    #1;
    check(req, bus_rdata, exp);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] held;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values
    peek("R1", 0, 32'h0); peek("R1", 1, 32'h0);
    peek("R1", 2, 32'h0000FFFF); peek("R1", 3, 32'h0);
    check("R1", 32'(irq), 32'h0);

    // R3: load from start value with counting stopped, data ignored
    cur_req = "R3";
    cyc(1'b1, 1'b0, 3, 32'd5);
    cyc(1'b1, 1'b0, 2, 32'd9);
    cyc(1'b1, 1'b0, 1, 32'hDEAD);
    peek("R3", 1, 32'd5);

    // R2: bus clock source, divide by 1, wrap 9 -> 5
    cur_req = "R2";
    cyc(1'b1, 1'b0, 0, ctl(1, 0, 1, 1, 0));
    idle(30, 1);
    check("R7", 32'(irq), 32'h1);

    // R8: clear handshake
    cur_req = "R8";
    cyc(1'b1, 1'b0, 0, ctl(0, 0, 1, 1, 0));
    cyc(1'b1, 1'b0, 0, ctl(0, 0, 1, 0, 0));
    peek("R8", 0, ctl(0, 0, 1, 1, 0));
    cyc(1'b1, 1'b0, 0, ctl(0, 0, 1, 1, 0));
    peek("R8", 0, ctl(0, 0, 1, 1, 0));
    cyc(1'b0, 1'b1, 0, '0);
    cyc(1'b1, 1'b0, 0, ctl(0, 0, 1, 0, 0));
    peek("R8", 0, ctl(0, 0, 1, 0, 0));
    check("R7", 32'(irq), 32'h0);

    // R6: threshold 2 -> flag on third overflow (every 5 ticks)
    cur_req = "R6";
    cyc(1'b1, 1'b0, 1, 32'h0);
    cyc(1'b1, 1'b0, 0, ctl(1, 0, 0, 1, 2));
    idle(12, 0);
    check("R6", 32'(bus_rdata[7]), 32'h0);
    idle(3, 0);
    check("R6", 32'(bus_rdata[7]), 32'h1);
    idle(20, 1);

    // R9: clear coinciding with a flag-setting overflow
    cur_req = "R9";
    cyc(1'b1, 1'b0, 0, ctl(1, 0, 1, 1, 0));
    cyc(1'b0, 1'b1, 0, '0);
    while (m_cnt != m_mod) cyc(1'b0, 1'b0, 1, '0);
    cyc(1'b1, 1'b0, 0, ctl(1, 0, 1, 0, 0));
    check("R9", 32'(bus_rdata[7]), 32'h1);
    cyc(1'b1, 1'b0, 0, ctl(1, 0, 1, 0, 0));
    check("R9", 32'(bus_rdata[7]), 32'h1);
    cyc(1'b0, 1'b1, 0, '0);
    cyc(1'b1, 1'b0, 0, ctl(1, 0, 1, 0, 0));
    check("R9", 32'(bus_rdata[7]), 32'h0);

    // R4: divide by 4 from a cleared prescale count
    cur_req = "R4";
    cyc(1'b1, 1'b0, 0, ctl(0, 0, 0, 1, 0));
    cyc(1'b1, 1'b0, 1, 32'h0);
    cyc(1'b1, 1'b0, 0, ctl(1, 2, 0, 1, 0));
    idle(8, 1);
    check("R4", bus_rdata, 32'd7);
    idle(30, 1);
    // R5: fixed strobe source with divide by 8
    cur_req = "R5";
    cyc(1'b1, 1'b0, 0, ctl(2, 3, 1, 1, 0));
    idle(120, 1);
    // R5: source 3 stops the counter
    cyc(1'b1, 1'b0, 0, ctl(3, 0, 1, 1, 0));
    held = 32'(m_cnt);
    idle(10, 1);
    check("R5", bus_rdata, held);

    // R10: reserved bits
    cur_req = "R10";
    cyc(1'b1, 1'b0, 0, 32'hFFFFF040 | ctl(0, 1, 1, 1, 3));
    peek("R10", 0, ctl(0, 1, 1, m_flag, 3));
    cyc(1'b1, 1'b0, 2, 32'hABCD0007);
    peek("R10", 2, 32'h00000007);
    cyc(1'b1, 1'b0, 3, 32'h12340002);
    peek("R10", 3, 32'h00000002);
    cyc(1'b1, 1'b0, 1, 32'hFFFFFFFF);
    peek("R10", 1, 32'h00000002);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule